// File: doc/BRIEF.md
# Integer Multiply/Divide Unit with HI/LO Result Pair

This block is the multicycle integer arithmetic engine that sits beside a processor's main datapath. It takes two 32-bit operands and one of four operations (multiply or divide, each signed or unsigned) through a start/busy handshake. It computes the result one bit per cycle, using shift-and-add for products and restoring subtraction for quotients. The answer goes into a dedicated pair of result registers, HI and LO, which are kept apart from the general registers.

A product fills both halves: its upper 32 bits go to HI and its lower 32 bits go to LO. A division puts the quotient in LO and the remainder in HI. The two registers are always visible on their own read ports. This serves the move-from-HI and move-from-LO operations of the pipeline. No overflow condition is reported for any operation. Software that needs to detect overflow inspects HI itself.

Top module: `muldiv_unit`

## Requirements
- R1: Operation code 2'b00 is a signed multiply. HI receives bits 63:32 and LO receives bits 31:0 of the two's-complement 64-bit product of the operands.
- R2: Operation code 2'b01 is an unsigned multiply. HI receives the upper half and LO the lower half of the unsigned 64-bit product.
- R3: Operation code 2'b10 is a signed divide.
  - LO receives the quotient, truncated toward zero.
  - HI receives the remainder, which carries the sign of the dividend, so that dividend = quotient × divisor + remainder.
  - The case 0x80000000 / 0xFFFFFFFF wraps silently to quotient 0x80000000 and remainder 0.
- R4: Operation code 2'b11 is an unsigned divide, with the quotient in LO and the remainder in HI.
- R5: A divide (code 2'b10 or 2'b11) by a zero divisor completes in the normal time. LO becomes all ones and HI becomes the dividend, unchanged.
- R6: A start seen while idle raises busy one cycle later. Busy then stays high for exactly 32 cycles, and HI/LO carry the new result in the cycle busy falls.
- R7: HI and LO keep their previous values in every cycle in which busy is high, and in every idle cycle without a start. They change only when an operation completes.
- R8: A start asserted while busy is ignored. The running operation's result and its completion cycle are unaffected by the new operands and operation code.
- R9: After reset, busy is low and both HI and LO read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new operation (accepted only when idle) |
| op | input | 2 | Operation: 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opa | input | 32 | Multiplicand or dividend |
| opb | input | 32 | Multiplier or divisor |
| busy | output | 1 | High while an operation is in progress |
| hi_out | output | 32 | HI register: product upper half or remainder |
| lo_out | output | 32 | LO register: product lower half or quotient |

## Verification
A new start request and a running operation can meet in the same cycle. The unit must let the iteration win and drop the request. This is provoked by pulsing start with fresh operands and a different operation code partway through a run, and again on the very cycle the run completes. The check then confirms two things: HI/LO match the first operation's reference value, and busy still falls exactly 32 cycles after the accepted start.

A second collision sits at the end of a run. The completion cycle writes HI/LO while the next start may already be waiting. Issuing operations back to back shows that each result is intact before the next one is accepted.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
    typedef enum logic [1:0] {
        OP_MUL_S = 2'b00,
        OP_MUL_U = 2'b01,
        OP_DIV_S = 2'b10,
        OP_DIV_U = 2'b11
    } md_op_e;
endpackage

// File: rtl/muldiv_prep.sv
// Operand conditioning: magnitudes and result sign decisions.
module muldiv_prep #(
    parameter int W = 32
) (
    input  muldiv_pkg::md_op_e op,
    input  logic [W-1:0]       a,
    input  logic [W-1:0]       b,
    output logic [W-1:0]       a_mag,
    output logic [W-1:0]       b_mag,
    output logic               is_div,
    output logic               neg_hi,
    output logic               neg_lo
);
    logic signed_op;
    logic a_neg;
    logic b_neg;
    logic b_zero;

    always_comb begin
        signed_op = ~op[0];
        is_div    = op[1];
        a_neg     = signed_op & a[W-1];
        b_neg     = signed_op & b[W-1];
        b_zero    = (b == '0);
        a_mag     = a_neg ? (~a + 1'b1) : a;
        b_mag     = b_neg ? (~b + 1'b1) : b;
        if (is_div) begin
            // quotient keeps all ones on zero divisor; remainder follows dividend
            neg_lo = (a_neg ^ b_neg) & ~b_zero;
            neg_hi = a_neg;
        end else begin
            neg_lo = a_neg ^ b_neg;
            neg_hi = a_neg ^ b_neg;
        end
    end
endmodule

// File: rtl/muldiv_step.sv
// One iteration: shift-add multiply or restoring divide.
module muldiv_step #(
    parameter int W = 32
) (
    input  logic         is_div,
    input  logic [W-1:0] acc_hi,
    input  logic [W-1:0] acc_lo,
    input  logic [W-1:0] opnd,
    output logic [W-1:0] nxt_hi,
    output logic [W-1:0] nxt_lo
);
    logic [W:0] sum;
    logic [W:0] shifted;
    logic [W:0] trial;
    logic       fits;

    always_comb begin
        sum     = {1'b0, acc_hi} + (acc_lo[0] ? {1'b0, opnd} : '0);
        shifted = {acc_hi, acc_lo[W-1]};
        fits    = (shifted >= {1'b0, opnd});
        trial   = shifted - {1'b0, opnd};
        if (is_div) begin
            nxt_hi = fits ? trial[W-1:0] : shifted[W-1:0];
            nxt_lo = {acc_lo[W-2:0], fits};
        end else begin
            nxt_hi = sum[W:1];
            nxt_lo = {sum[0], acc_lo[W-1:1]};
        end
    end
endmodule

// File: rtl/muldiv_fix.sv
// Final sign correction applied to the raw magnitude result.
module muldiv_fix #(
    parameter int W = 32
) (
    input  logic         is_div,
    input  logic         neg_hi,
    input  logic         neg_lo,
    input  logic [W-1:0] raw_hi,
    input  logic [W-1:0] raw_lo,
    output logic [W-1:0] res_hi,
    output logic [W-1:0] res_lo
);
    localparam int DW = 2 * W;
    logic [DW-1:0] prod;

    always_comb begin
        prod = {raw_hi, raw_lo};
        if (neg_lo) prod = ~prod + 1'b1;
        if (is_div) begin
            res_hi = neg_hi ? (~raw_hi + 1'b1) : raw_hi;
            res_lo = neg_lo ? (~raw_lo + 1'b1) : raw_lo;
        end else begin
            res_hi = prod[DW-1:W];
            res_lo = prod[W-1:0];
        end
    end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         busy,
    output logic [W-1:0] hi_out,
    output logic [W-1:0] lo_out
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic          is_div;
        logic          neg_hi;
        logic          neg_lo;
        logic [W-1:0]  acc_hi;
        logic [W-1:0]  acc_lo;
        logic [W-1:0]  opnd;
        logic [W-1:0]  hi;
        logic [W-1:0]  lo;
    } md_state_t;

    md_state_t st_q, st_d;

    logic [W-1:0] a_mag, b_mag;
    logic         p_is_div, p_neg_hi, p_neg_lo;
    logic [W-1:0] step_hi, step_lo;
    logic [W-1:0] fix_hi, fix_lo;

    muldiv_prep #(.W(W)) u_prep (
        .op     (muldiv_pkg::md_op_e'(op)),
        .a      (opa),
        .b      (opb),
        .a_mag  (a_mag),
        .b_mag  (b_mag),
        .is_div (p_is_div),
        .neg_hi (p_neg_hi),
        .neg_lo (p_neg_lo)
    );

    muldiv_step #(.W(W)) u_step (
        .is_div (st_q.is_div),
        .acc_hi (st_q.acc_hi),
        .acc_lo (st_q.acc_lo),
        .opnd   (st_q.opnd),
        .nxt_hi (step_hi),
        .nxt_lo (step_lo)
    );

    muldiv_fix #(.W(W)) u_fix (
        .is_div (st_q.is_div),
        .neg_hi (st_q.neg_hi),
        .neg_lo (st_q.neg_lo),
        .raw_hi (step_hi),
        .raw_lo (step_lo),
        .res_hi (fix_hi),
        .res_lo (fix_lo)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy   = 1'b1;
                st_d.cnt    = '0;
                st_d.is_div = p_is_div;
                st_d.neg_hi = p_neg_hi;
                st_d.neg_lo = p_neg_lo;
                st_d.acc_hi = '0;
                st_d.acc_lo = a_mag;
                st_d.opnd   = b_mag;
            end
        end else begin
            st_d.acc_hi = step_hi;
            st_d.acc_lo = step_lo;
            st_d.cnt    = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.hi   = fix_hi;
                st_d.lo   = fix_lo;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = st_q.busy;
    assign hi_out = st_q.hi;
    assign lo_out = st_q.lo;
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic [W-1:0] hi_out,
    input logic [W-1:0] lo_out
);
    localparam int RW = $clog2(W) + 2;
    logic [RW-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    p_run_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == RW'(W)));

    p_run_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < RW'(W)));

    p_hold_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($stable(hi_out) && $stable(lo_out)));

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(hi_out) && $stable(lo_out)));

    p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && run_len < RW'(W - 1)) |=> busy);
endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W)) u_chk (.*);

// File: tb/muldiv_unit_test.sv
`timescale 1ns/1ps
module muldiv_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        busy;
    logic [31:0] hi_out, lo_out;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    muldiv_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .opa(opa), .opb(opb), .busy(busy), .hi_out(hi_out), .lo_out(lo_out)
    );

    function automatic logic [63:0] model(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
        longint sa, sb, q, r;
        logic [63:0] p;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        case (o)
            2'b00: begin q = sa * sb; p = q; end
            2'b01: p = {32'b0, a} * {32'b0, b};
            2'b10: begin
                if (b == 0) p = {a, 32'hFFFF_FFFF};
                else begin q = sa / sb; r = sa % sb; p = {r[31:0], q[31:0]}; end
            end
            default: begin
                if (b == 0) p = {a, 32'hFFFF_FFFF};
                else p = {a % b, a / b};
            end
        endcase
        return p;
    endfunction

    function automatic string req_of(input logic [1:0] o, input logic [31:0] b);
        if (o[1] && b == 0) return "R5";
        case (o)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one operation; optional disturbing start at cycle 'hit' (0 = none, 32 = completion cycle).
    task automatic run_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b, input int hit);
        logic [63:0] exp, prev;
        bit busy_ok;
        exp  = model(o, a, b);
        prev = {hi_out, lo_out};
        op = o; opa = a; opb = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0; opa = ~a; opb = b + 32'd7; op = ~o;
        chk(busy === 1'b1, "R6", {63'b0, busy}, 64'd1);
        busy_ok = 1'b1;
        for (int i = 1; i < 32; i++) begin
            if (hit != 0 && i == hit) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            if (busy !== 1'b1) busy_ok = 1'b0;
            if ({hi_out, lo_out} !== prev) busy_ok = 1'b0;
        end
        chk(busy_ok, "R7", {hi_out, lo_out}, prev);
        if (hit != 0) start = 1'b1;
        @(negedge clk);
        if (hit != 0) begin
            chk(busy === 1'b0, "R8", {63'b0, busy}, 64'd0);
            chk({hi_out, lo_out} === exp, "R8", {hi_out, lo_out}, exp);
            // the completion-cycle start must also have been dropped
            start = 1'b0;
            @(negedge clk);
            chk(busy === 1'b0, "R8", {63'b0, busy}, 64'd0);
            chk({hi_out, lo_out} === exp, "R7", {hi_out, lo_out}, exp);
        end else begin
            chk(busy === 1'b0, "R6", {63'b0, busy}, 64'd0);
            chk({hi_out, lo_out} === exp, req_of(o, b), {hi_out, lo_out}, exp);
        end
        start = 1'b0;
    endtask

    function automatic logic [31:0] pick();
        case ($urandom % 8)
            0: return 32'h0;
            1: return 32'h1;
            2: return 32'hFFFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'h7FFF_FFFF;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1BAD_5EED));
        repeat (3) @(negedge clk);
        chk(busy === 1'b0, "R9", {63'b0, busy}, 64'd0);
        chk({hi_out, lo_out} === 64'd0, "R9", {hi_out, lo_out}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // idle cycles without start leave HI/LO alone
        repeat (4) @(negedge clk);
        chk({hi_out, lo_out} === 64'd0 && busy === 1'b0, "R7", {hi_out, lo_out}, 64'd0);

        // directed corner cases
        run_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);   // R1: -1 * -1
        run_op(2'b00, 32'h8000_0000, 32'h8000_0000, 0);   // R1
        run_op(2'b00, 32'h8000_0000, 32'h0000_0003, 0);   // R1
        run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);   // R2
        run_op(2'b10, 32'hFFFF_FFF9, 32'h0000_0002, 0);   // R3: -7/2 -> -3 r -1
        run_op(2'b10, 32'h0000_0007, 32'hFFFF_FFFE, 0);   // R3: 7/-2 -> -3 r 1
        run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 0);   // R3: wrap case
        run_op(2'b11, 32'h0000_004A, 32'h0000_0008, 0);   // R4
        run_op(2'b11, 32'hFFFF_FFFF, 32'h0000_0001, 0);   // R4
        run_op(2'b10, 32'hFFFF_FF00, 32'h0000_0000, 0);   // R5 signed
        run_op(2'b11, 32'h1234_5678, 32'h0000_0000, 0);   // R5 unsigned
        run_op(2'b01, 32'h0000_1234, 32'h0000_5678, 10);  // R8 mid-run start
        run_op(2'b10, 32'hFFFF_FC00, 32'h0000_0013, 31);  // R8 late start

        // constrained random, back-to-back
        for (int k = 0; k < 240; k++) begin
            logic [1:0] o;
            o = 2'($urandom);
            run_op(o, pick(), pick(), (k % 17 == 0) ? int'($urandom % 31) + 1 : 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule